// File: doc/BRIEF.md
# Five-Input Configurable Logic Cell

This block models one programmable logic cell of a reconfigurable fabric. Five logic inputs and the outputs of two internal flip-flops form seven candidate table inputs. A 32-entry, 1-bit lookup table computes two combinational results, F and G. The table can act as one 5-input function, as two separate 4-input functions, or as two 16-entry halves with a 2:1 selector driven by any candidate. A clock-enabled register pair with an asynchronous clear captures F and G. Each of the two cell outputs shows either its combinational result or its register.

The whole configuration is a 63-bit word loaded one bit per clock over a serial port while the cell is idle. The first bit shifted in ends up as table entry 0. Split-mode configurations that draw too few inputs from the logic pins are flagged on an error output.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `cfg_shift_en` is high, each rising clock edge shifts `cfg_data` into the configuration word at bit 62 and moves every other bit down by one. After 63 shifts, the first bit sent is at bit 0. While `cfg_shift_en` is low, the word holds. Layout: bits 31:0 are table entries 0..31, 33:32 the mode, 36:34/39:37/42:40/45:43 the F selects fs0..fs3, 48:46/51:49/54:52/57:55 the G selects gs0..gs3, 60:58 the top select, 61 the X source and 62 the Y source.
- R2: Select code values 0..4 pick logic inputs A..E (`lin[0]`..`lin[4]`), 5 picks register QX, 6 picks register QY, and 7 gives constant 0.
- R3: In mode 0 (five-input), the table index is {top, fs3, fs2, fs1, fs0}, with fs0 as the LSB. F and G both equal that entry, so an all-ones index reads entry 31.
- R4: In mode 1 (split), F is the entry at {0, fs3..fs0} and G is the entry at {1, gs3..gs0}. The two are independent 4-input functions.
- R5: In mode 2 (selected halves), F and G both equal the upper-half entry {1, gs3..gs0} when the top candidate is 1, and the lower-half entry {0, fs3..fs0} otherwise.
- R6: Output X shows QX when bit 61 is 1 and F when it is 0. Output Y shows QY when bit 62 is 1 and G when it is 0.
- R7: On a rising clock edge with `cen` high, QX loads F and QY loads G. With `cen` low, both hold.
- R8: `arst` high clears QX and QY at once, independent of the clock.
- R9: In mode 1, `cfg_err` is 1 when fewer than two of fs0..fs3, or fewer than two of gs0..gs3, hold a code in 0..4. Otherwise it is 0 in modes 0..2.
- R10: Mode 3 is reserved. It sets `cfg_err` to 1 and forces F and G to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| arst | input | 1 | Asynchronous direct clear of both registers, active high |
| cen | input | 1 | Register clock enable |
| lin | input | 5 | Logic inputs A (bit 0) to E (bit 4) |
| cfg_shift_en | input | 1 | Shift enable of the configuration port |
| cfg_data | input | 1 | Serial configuration bit |
| out_x | output | 1 | Cell output X |
| out_y | output | 1 | Cell output Y |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
In one cycle, a register load and its feedback into the table index can both act, while the other output still shows the combinational path. The bench sets up a toggling configuration: QX is the only table input, X is combinational and Y is registered. On each enabled edge, Y takes the new register value and X shows the inverted value computed from it at the same time. Both are compared against the expected alternation after every edge, after a disabled edge, and after an asynchronous clear applied mid-cycle.

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell #(
  parameter int N_IN  = 5,
  parameter int SEL_W = 3
) (
  input  logic            clk,
  input  logic            arst,
  input  logic            cen,
  input  logic [N_IN-1:0] lin,
  input  logic            cfg_shift_en,
  input  logic            cfg_data,
  output logic            out_x,
  output logic            out_y,
  output logic            cfg_err
);
  localparam int LUT_N  = 1 << N_IN;
  localparam int HALF   = N_IN - 1;
  localparam int N_CAND = 1 << SEL_W;
  localparam int MODE_LO = LUT_N;
  localparam int FS_LO  = MODE_LO + 2;
  localparam int GS_LO  = FS_LO + HALF * SEL_W;
  localparam int TOP_LO = GS_LO + HALF * SEL_W;
  localparam int XS_BIT = TOP_LO + SEL_W;
  localparam int YS_BIT = XS_BIT + 1;
  localparam int CFG_W  = YS_BIT + 1;

  logic [CFG_W-1:0] cfg;
  logic [LUT_N-1:0] lut;
  logic [1:0]       mode;
  logic [N_CAND-1:0] cand;
  logic [HALF-1:0]  f_idx, g_idx, f_ok, g_ok;
  logic             top_bit, lo_val, hi_val, full_val;
  logic             f_w, g_w, qx, qy;

  always_ff @(posedge clk)
    if (cfg_shift_en) cfg <= {cfg_data, cfg[CFG_W-1:1]};

  assign lut  = cfg[LUT_N-1:0];
  assign mode = cfg[MODE_LO +: 2];
  assign cand = {{(N_CAND-N_IN-2){1'b0}}, qy, qx, lin};

  for (genvar k = 0; k < HALF; k++) begin : g_sel
    logic [SEL_W-1:0] fc, gc;
    assign fc = cfg[FS_LO + k*SEL_W +: SEL_W];
    assign gc = cfg[GS_LO + k*SEL_W +: SEL_W];
    assign f_idx[k] = cand[fc];
    assign g_idx[k] = cand[gc];
    assign f_ok[k]  = (fc < SEL_W'(N_IN));
    assign g_ok[k]  = (gc < SEL_W'(N_IN));
  end

  assign top_bit  = cand[cfg[TOP_LO +: SEL_W]];
  assign lo_val   = lut[{1'b0, f_idx}];
  assign hi_val   = lut[{1'b1, g_idx}];
  assign full_val = lut[{top_bit, f_idx}];

  always_comb begin
    case (mode)
      2'd0:    begin f_w = full_val; g_w = full_val; end
      2'd1:    begin f_w = lo_val;   g_w = hi_val;   end
      2'd2:    begin f_w = top_bit ? hi_val : lo_val; g_w = f_w; end
      default: begin f_w = 1'b0;     g_w = 1'b0;     end
    endcase
  end

  always_comb begin
    case (mode)
      2'd1:    cfg_err = ($countones(f_ok) < 2) || ($countones(g_ok) < 2);
      2'd3:    cfg_err = 1'b1;
      default: cfg_err = 1'b0;
    endcase
  end

  always_ff @(posedge clk or posedge arst)
    if (arst) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else if (cen) begin
      qx <= f_w;
      qy <= g_w;
    end

  assign out_x = cfg[XS_BIT] ? qx : f_w;
  assign out_y = cfg[YS_BIT] ? qy : g_w;
endmodule

module cfg_logic_cell_chk #(
  parameter int CFG_W = 63
) (
  input logic             clk,
  input logic             arst,
  input logic             cen,
  input logic             cfg_shift_en,
  input logic             cfg_data,
  input logic [CFG_W-1:0] cfg,
  input logic [1:0]       mode,
  input logic             f_w,
  input logic             g_w,
  input logic             qx,
  input logic             qy,
  input logic             cfg_err
);
  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (arst)
    cfg_shift_en |=> cfg[CFG_W-1] == $past(cfg_data));
  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (arst)
    !cfg_shift_en |=> $stable(cfg));
  // R7
  reg_load_chk: assert property (@(posedge clk) disable iff (arst)
    cen |=> (qx == $past(f_w)) && (qy == $past(g_w)));
  // R7
  reg_hold_chk: assert property (@(posedge clk) disable iff (arst)
    !cen |=> $stable(qx) && $stable(qy));
  // R8
  always @(posedge clk)
    if (arst) rst_clear_chk: assert (qx == 1'b0 && qy == 1'b0);
  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (arst)
    (mode == 2'd3) |-> cfg_err && !f_w && !g_w);
  // R9
  err_mode_chk: assert property (@(posedge clk) disable iff (arst)
    (cfg_err && mode != 2'd3) |-> mode == 2'd1);
endmodule

bind cfg_logic_cell cfg_logic_cell_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .arst(arst), .cen(cen), .cfg_shift_en(cfg_shift_en),
  .cfg_data(cfg_data), .cfg(cfg), .mode(mode), .f_w(f_w), .g_w(g_w),
  .qx(qx), .qy(qy), .cfg_err(cfg_err)
);

// File: tb/cfg_logic_cell_bench.sv
`timescale 1ns/1ps
module cfg_logic_cell_bench;
  logic clk = 1'b0, arst = 1'b1, cen = 1'b0, cfg_shift_en = 1'b0, cfg_data = 1'b0;
  logic [4:0] lin = '0;
  logic out_x, out_y, cfg_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_logic_cell u_cfg_logic_cell (
    .clk(clk), .arst(arst), .cen(cen), .lin(lin), .cfg_shift_en(cfg_shift_en),
    .cfg_data(cfg_data), .out_x(out_x), .out_y(out_y), .cfg_err(cfg_err)
  );

  function automatic logic [62:0] mk(input logic [31:0] t, input logic [1:0] m,
      input logic [2:0] f0, f1, f2, f3, g0, g1, g2, g3, tp, input logic xr, yr);
    return {yr, xr, tp, g3, g2, g1, g0, f3, f2, f1, f0, m, t};
  endfunction

  logic [62:0] cfgs [3];
  // {config id, lin, expected X, expected Y}
  localparam logic [8:0] VEC [16] = '{
    {2'd0, 5'h1F, 1'b1, 1'b1}, {2'd0, 5'h0F, 1'b0, 1'b0},
    {2'd0, 5'h10, 1'b0, 1'b0}, {2'd0, 5'h1E, 1'b0, 1'b0},
    {2'd1, 5'h00, 1'b0, 1'b0}, {2'd1, 5'h01, 1'b1, 1'b0},
    {2'd1, 5'h03, 1'b0, 1'b1}, {2'd1, 5'h10, 1'b0, 1'b1},
    {2'd1, 5'h0F, 1'b0, 1'b1}, {2'd1, 5'h07, 1'b1, 1'b1},
    {2'd2, 5'h00, 1'b0, 1'b0}, {2'd2, 5'h01, 1'b1, 1'b1},
    {2'd2, 5'h10, 1'b1, 1'b1}, {2'd2, 5'h12, 1'b0, 1'b0},
    {2'd2, 5'h13, 1'b0, 1'b0}, {2'd2, 5'h02, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [62:0] w);
    for (int i = 0; i < 63; i++) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_data = w[i];
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // AND5 in five-input mode, parity4/OR4 split, selected halves E ? !B : A
    cfgs[0] = mk(32'h8000_0000, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd7, 3'd7, 3'd7, 3'd4, 1'b0, 1'b0);
    cfgs[1] = mk({16'hFFFE, 16'h6996}, 2'd1, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd3, 3'd2, 3'd1, 3'd7, 1'b0, 1'b0);
    cfgs[2] = mk({16'h0001, 16'h0002}, 2'd2, 3'd0, 3'd7, 3'd7, 3'd7, 3'd1, 3'd7, 3'd7, 3'd7, 3'd4, 1'b0, 1'b0);

    // R8 reset state with both outputs registered (R6)
    load_cfg(mk(32'hFFFF_FFFF, 2'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd7, 3'd7, 3'd7, 3'd4, 1'b1, 1'b1));
    #1;
    chk("R8 reset X", out_x, 1'b0);
    chk("R8 reset Y", out_y, 1'b0);
    arst = 1'b0;

    // R1 R2 R3 R4 R5 vector walk
    for (int v = 0; v < 16; v++) begin
      if (v == 0 || VEC[v][8:7] != VEC[v-1][8:7]) load_cfg(cfgs[VEC[v][8:7]]);
      @(negedge clk);
      lin = VEC[v][6:2];
      #1;
      chk($sformatf("R3/R4/R5 cfg%0d lin=%h X", VEC[v][8:7], VEC[v][6:2]), out_x, VEC[v][1]);
      chk($sformatf("R3/R4/R5 cfg%0d lin=%h Y", VEC[v][8:7], VEC[v][6:2]), out_y, VEC[v][0]);
      chk("R9 legal cfg no error", cfg_err, 1'b0);
    end

    // R9 split rule broken in F group, then in G group
    load_cfg(mk(32'h0, 2'd1, 3'd0, 3'd5, 3'd6, 3'd7, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7, 1'b0, 1'b0));
    #1; chk("R9 F group error", cfg_err, 1'b1);
    load_cfg(mk(32'h0, 2'd1, 3'd0, 3'd1, 3'd5, 3'd6, 3'd5, 3'd6, 3'd7, 3'd0, 3'd7, 1'b0, 1'b0));
    #1; chk("R9 G group error", cfg_err, 1'b1);

    // R10 reserved mode
    load_cfg(mk(32'hFFFF_FFFF, 2'd3, 3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd7, 3'd7, 3'd7, 3'd4, 1'b0, 1'b0));
    lin = 5'h1F; #1;
    chk("R10 reserved error", cfg_err, 1'b1);
    chk("R10 reserved X", out_x, 1'b0);
    chk("R10 reserved Y", out_y, 1'b0);

    // R7 R2 R6 toggle via QX feedback: X combinational, Y registered
    arst = 1'b1;
    load_cfg(mk(32'h0000_0001, 2'd0, 3'd5, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 1'b0, 1'b1));
    arst = 1'b0; #1;
    chk("R2 QX=0 feeds index X", out_x, 1'b1);
    chk("R6 Y registered", out_y, 1'b0);
    cen = 1'b1;
    @(negedge clk); #1;
    chk("R7 edge1 X", out_x, 1'b0);
    chk("R7 edge1 Y", out_y, 1'b1);
    @(negedge clk); #1;
    chk("R7 edge2 X", out_x, 1'b1);
    chk("R7 edge2 Y", out_y, 1'b0);
    @(negedge clk); #1;
    cen = 1'b0;
    @(negedge clk); #1;
    chk("R7 hold X", out_x, 1'b0);
    chk("R7 hold Y", out_y, 1'b1);
    // R8 asynchronous clear mid-cycle
    #0.5 arst = 1'b1; #0.2;
    chk("R8 async X", out_x, 1'b1);
    chk("R8 async Y", out_y, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule